// File: doc/BRIEF.md
# Serial DAC Control-Port Sequencer

This block drives the three-wire control interface of an audio DAC. The interface has a serial clock, a serial data line and a latch line. The block also drives an active-low reset output to the converter. A host hands it register writes on a valid/ready handshake, each write being a 7-bit register index and a 9-bit value. The block packs each write into one 16-bit control word and shifts it out at a fixed bit rhythm. The rhythm is set by a phase length in clock cycles. The latch pulses low after the last bit, and an idle gap follows each word.

After its own reset the block runs a power-up routine with no help from the host. It waits, pulses the converter reset low, then waits for the converter to settle. It then writes the default left and right attenuation, clears the mute register and loads the default format word. The host handshake stays closed until that routine has finished. Once open, the host uses it for run-time updates such as volume changes. A word that has started always completes before the next request is taken.

Top module: `dac_ctl_seq`

## Requirements
- R1: Each word carries the register index in bits 15:9 and the value in bits 8:0. It is sent MSB first as exactly 16 bits, and a bit is sampled on each rising edge of `dac_clk_o`.
- R2: For every bit, `dac_clk_o` stays low for 3 phases; `dac_dat_o` changes only while the clock is low. Between two bits of one word, the clock stays high for exactly 1 phase (one phase = PHASE_CYC cycles).
- R3: `dac_latch_o` stays high while a word shifts. It falls 1 phase after the rising clock of bit 0, stays low for exactly 2 phases, then returns high.
- R4: After the latch returns high, at least 4 phases pass before the next word's first clock falls.
- R5: After reset, `dac_rst_no` stays high for PRE_CYC cycles, then low for exactly RST_CYC cycles. The first clock fall comes no sooner than SETTLE_CYC cycles after `dac_rst_no` rises.
- R6: The power-up routine sends four words in this order: index 0 with value 0x108, index 1 with value 0x108, index 2 with value 0x000, index 3 with value 0x099. Bit 8 of the volume value is the load flag, and 0x08 is the attenuation code.
- R7: `req_ready_o` stays low until the fourth power-up word has been latched.
- R8: `req_ready_o` is high only while no word is in progress, and it falls after an accepted request. The word sent is the index and value present in the cycle of acceptance. A request raised while ready is low is not taken until ready rises, so it cannot break into a word.
- R9: While `rst_ni` is low, the clock, latch and converter-reset outputs are high and `req_ready_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Host write request valid |
| req_ready_o | output | 1 | Block can take a write this cycle |
| req_reg_i | input | 7 | Register index of the write |
| req_val_i | input | 9 | Register value of the write |
| dac_clk_o | output | 1 | Control-port serial clock |
| dac_dat_o | output | 1 | Control-port serial data |
| dac_latch_o | output | 1 | Control-port latch, low pulse ends a word |
| dac_rst_no | output | 1 | Active-low converter reset |

## Verification
An accepted request takes effect on the next clock edge: the serial clock falls one cycle after acceptance. After that every event sits on a whole number of phases. The data changes 1 phase after the clock falls and the clock rises 2 phases later. The latch falls 1 phase after the last rise, and the next word's earliest clock fall is 4 phases plus one cycle after the latch rises. The bench samples all outputs on the falling system clock edge and measures each interval by counting those samples. It checks the exact phase counts, the lower bounds for the gaps, and the decoded word on every latch fall.

// File: rtl/dac_ctl_pkg.sv
package dac_ctl_pkg;
  localparam int unsigned IDX_W  = 7;
  localparam int unsigned VAL_W  = 9;
  localparam int unsigned WORD_W = IDX_W + VAL_W;
  localparam int unsigned BOOT_N = 4;

  localparam logic [VAL_W-1:0] VOL_LOAD = 9'h100;
  localparam logic [VAL_W-1:0] DEF_ATT  = 9'h008;
  localparam logic [VAL_W-1:0] DEF_FMT  = 9'h099;

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic [VAL_W-1:0] val;
  } ctl_word_t;

  typedef enum logic [2:0] {
    SH_IDLE, SH_LOW, SH_SETUP, SH_HIGH, SH_LATCH, SH_GAP
  } sh_state_e;

  typedef enum logic [2:0] {
    BT_PRE, BT_RST, BT_SETTLE, BT_LOAD, BT_DONE
  } bt_state_e;

  function automatic ctl_word_t boot_word(input logic [1:0] k);
    ctl_word_t w;
    w.idx = IDX_W'(k);
    case (k)
      2'd0, 2'd1: w.val = VOL_LOAD | DEF_ATT;
      2'd2:       w.val = '0;
      default:    w.val = DEF_FMT;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/dac_ctl_timer.sv
module dac_ctl_timer #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned RST_LEN = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] RST_CNT = (RST_LEN == 0) ? '0 : CNT_W'(RST_LEN - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= RST_CNT;
    else if (load_i)         cnt_q <= len_i - 1'b1;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/dac_ctl_shift.sv
module dac_ctl_shift
  import dac_ctl_pkg::*;
#(
  parameter int unsigned PHASE_CYC = 300
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              idle_o,
  output logic              sclk_o,
  output logic              sdat_o,
  output logic              latch_o
);
  localparam int unsigned CNT_W = $clog2(4 * PHASE_CYC + 1);
  localparam int unsigned BIT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LEN_1 = CNT_W'(PHASE_CYC);
  localparam logic [CNT_W-1:0] LEN_2 = CNT_W'(2 * PHASE_CYC);
  localparam logic [CNT_W-1:0] LEN_4 = CNT_W'(4 * PHASE_CYC);
  localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(WORD_W - 1);

  sh_state_e         st_q, st_d;
  logic              ld;
  logic [CNT_W-1:0]  len;
  logic              tdone;
  logic [WORD_W-1:0] word_q;
  logic [BIT_W-1:0]  bit_q;
  logic              clk_q, dat_q, lat_q;
  logic              last_bit;

  assign last_bit = (bit_q == '0);

  dac_ctl_timer #(.CNT_W(CNT_W), .RST_LEN(0)) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(ld),
    .len_i (len),
    .done_o(tdone)
  );

  always_comb begin
    st_d = st_q;
    len  = LEN_1;
    unique case (st_q)
      SH_IDLE:  if (start_i) begin st_d = SH_LOW; len = LEN_1; end
      SH_LOW:   if (tdone) begin st_d = SH_SETUP; len = LEN_2; end
      SH_SETUP: if (tdone) begin st_d = SH_HIGH; len = LEN_1; end
      SH_HIGH:  if (tdone) begin
                  st_d = last_bit ? SH_LATCH : SH_LOW;
                  len  = last_bit ? LEN_2 : LEN_1;
                end
      SH_LATCH: if (tdone) begin st_d = SH_GAP; len = LEN_4; end
      SH_GAP:   if (tdone) st_d = SH_IDLE;
      default:  st_d = SH_IDLE;
    endcase
    ld = (st_d != st_q) && (st_d != SH_IDLE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SH_IDLE;
      word_q <= '0;
      bit_q  <= '0;
      clk_q  <= 1'b1;
      dat_q  <= 1'b0;
      lat_q  <= 1'b1;
    end else begin
      st_q <= st_d;
      unique case (st_q)
        SH_IDLE: if (start_i) begin
          word_q <= word_i;
          bit_q  <= TOP_BIT;
          clk_q  <= 1'b0;
        end
        SH_LOW:   if (tdone) dat_q <= word_q[bit_q];
        SH_SETUP: if (tdone) clk_q <= 1'b1;
        SH_HIGH:  if (tdone) begin
          if (last_bit) lat_q <= 1'b0;
          else begin
            bit_q <= bit_q - 1'b1;
            clk_q <= 1'b0;
          end
        end
        SH_LATCH: if (tdone) lat_q <= 1'b1;
        default: ;
      endcase
    end
  end

  assign idle_o  = (st_q == SH_IDLE);
  assign sclk_o  = clk_q;
  assign sdat_o  = dat_q;
  assign latch_o = lat_q;
endmodule

// File: rtl/dac_ctl_boot.sv
module dac_ctl_boot
  import dac_ctl_pkg::*;
#(
  parameter int unsigned PRE_CYC    = 10000,
  parameter int unsigned RST_CYC    = 10000,
  parameter int unsigned SETTLE_CYC = 50000
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      take_i,
  output logic      valid_o,
  output ctl_word_t word_o,
  output logic      dac_rst_no,
  output logic      done_o
);
  localparam int unsigned MAX_AB  = (PRE_CYC > RST_CYC) ? PRE_CYC : RST_CYC;
  localparam int unsigned MAX_CYC = (MAX_AB > SETTLE_CYC) ? MAX_AB : SETTLE_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [1:0]  LAST_K  = 2'(BOOT_N - 1);

  bt_state_e        st_q, st_d;
  logic             ld;
  logic [CNT_W-1:0] len;
  logic             tdone;
  logic [1:0]       k_q;

  dac_ctl_timer #(.CNT_W(CNT_W), .RST_LEN(PRE_CYC)) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(ld),
    .len_i (len),
    .done_o(tdone)
  );

  always_comb begin
    st_d = st_q;
    ld   = 1'b0;
    len  = CNT_W'(RST_CYC);
    unique case (st_q)
      BT_PRE:    if (tdone) begin st_d = BT_RST; ld = 1'b1; len = CNT_W'(RST_CYC); end
      BT_RST:    if (tdone) begin st_d = BT_SETTLE; ld = 1'b1; len = CNT_W'(SETTLE_CYC); end
      BT_SETTLE: if (tdone) st_d = BT_LOAD;
      BT_LOAD:   if (take_i && k_q == LAST_K) st_d = BT_DONE;
      default:   st_d = BT_DONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= BT_PRE;
      k_q  <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == BT_LOAD && take_i) k_q <= k_q + 1'b1;
    end
  end

  assign valid_o    = (st_q == BT_LOAD);
  assign word_o     = boot_word(k_q);
  assign dac_rst_no = (st_q != BT_RST);
  assign done_o     = (st_q == BT_DONE);
endmodule

// File: rtl/dac_ctl_seq.sv
module dac_ctl_seq
  import dac_ctl_pkg::*;
#(
  parameter int unsigned PHASE_CYC  = 300,
  parameter int unsigned PRE_CYC    = 10000,
  parameter int unsigned RST_CYC    = 10000,
  parameter int unsigned SETTLE_CYC = 50000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [IDX_W-1:0] req_reg_i,
  input  logic [VAL_W-1:0] req_val_i,
  output logic             dac_clk_o,
  output logic             dac_dat_o,
  output logic             dac_latch_o,
  output logic             dac_rst_no
);
  logic      sh_idle, sh_start;
  logic      bt_valid, bt_take, bt_done;
  ctl_word_t bt_word, host_word, sel_word;

  dac_ctl_boot #(
    .PRE_CYC   (PRE_CYC),
    .RST_CYC   (RST_CYC),
    .SETTLE_CYC(SETTLE_CYC)
  ) u_boot (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .take_i    (bt_take),
    .valid_o   (bt_valid),
    .word_o    (bt_word),
    .dac_rst_no(dac_rst_no),
    .done_o    (bt_done)
  );

  assign host_word   = '{idx: req_reg_i, val: req_val_i};
  assign bt_take     = bt_valid && sh_idle;
  assign req_ready_o = bt_done && sh_idle;
  assign sh_start    = bt_take || (req_valid_i && req_ready_o);
  assign sel_word    = bt_done ? host_word : bt_word;

  dac_ctl_shift #(.PHASE_CYC(PHASE_CYC)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(sh_start),
    .word_i (sel_word),
    .idle_o (sh_idle),
    .sclk_o (dac_clk_o),
    .sdat_o (dac_dat_o),
    .latch_o(dac_latch_o)
  );
endmodule

// File: rtl/dac_ctl_seq_chk.sv
module dac_ctl_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_valid_i,
  input logic req_ready_o,
  input logic dac_clk_o,
  input logic dac_dat_o,
  input logic dac_latch_o,
  input logic dac_rst_no
);
  AST_DAT_STABLE_CLK_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_clk_o |-> $stable(dac_dat_o)) else $error("data moved with clock high"); // R2
  AST_LATCH_ONLY_CLK_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dac_latch_o |-> dac_clk_o) else $error("latch low with clock low"); // R3
  AST_NO_CLK_IN_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dac_clk_o) |-> (dac_latch_o && dac_rst_no)) else $error("clock fell in reset or latch"); // R5
  AST_NO_READY_IN_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dac_rst_no |-> !req_ready_o) else $error("ready during converter reset"); // R7
  AST_READY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (dac_clk_o && dac_latch_o)) else $error("ready while shifting"); // R8
  AST_READY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o) else $error("ready held after accept"); // R8
endmodule

bind dac_ctl_seq dac_ctl_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .dac_clk_o  (dac_clk_o),
  .dac_dat_o  (dac_dat_o),
  .dac_latch_o(dac_latch_o),
  .dac_rst_no (dac_rst_no)
);

// File: tb/tb_dac_ctl_seq.sv
module tb_dac_ctl_seq;
  localparam int CLK_PERIOD = 10;
  localparam int PH   = 4;
  localparam int PRE  = 20;
  localparam int RSTC = 30;
  localparam int SETC = 40;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_valid_i = 1'b0;
  logic       req_ready_o;
  logic [6:0] req_reg_i = '0;
  logic [8:0] req_val_i = '0;
  logic       dac_clk_o, dac_dat_o, dac_latch_o, dac_rst_no;

  dac_ctl_seq #(
    .PHASE_CYC(PH), .PRE_CYC(PRE), .RST_CYC(RSTC), .SETTLE_CYC(SETC)
  ) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_reg_i(req_reg_i), .req_val_i(req_val_i), .dac_clk_o(dac_clk_o),
    .dac_dat_o(dac_dat_o), .dac_latch_o(dac_latch_o), .dac_rst_no(dac_rst_no)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_tests = 0;
  int n_fail  = 0;
  logic [15:0] exp_q[$];
  int n_sent = 0;
  int words_seen = 0;
  bit boot_ready_bad = 0;
  bit busy_ready_bad = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_word(input logic [6:0] r, input logic [8:0] v);
    return {r, v};
  endfunction

  // serial monitor, sampled on falling system clock
  bit prev_c = 1, prev_l = 1, prev_r = 1;
  int lo_run = 0, hi_run = 0, lat_run = 0, since_rise = 0, gap_run = 0;
  int rst_lo_run = 0, settle_run = 0, pre_run = 0, bitcnt = 0;
  bit have_word = 0, first_fall = 0, rst_fell = 0;
  logic [15:0] shreg = '0;

  always @(negedge clk_i) begin
    if (rst_ni) begin
      logic [15:0] e;
      since_rise++;
      if (prev_r && !dac_rst_no) begin
        chk(pre_run >= PRE - 1, "R5 pre-reset wait", pre_run, PRE);
        rst_fell = 1; rst_lo_run = 0;
      end
      if (!prev_r && dac_rst_no) begin
        chk(rst_lo_run == RSTC, "R5 reset pulse width", rst_lo_run, RSTC);
        settle_run = 0;
      end
      if (!prev_c && dac_clk_o) begin
        chk(lo_run == 3*PH, "R2 clock low span", lo_run, 3*PH);
        shreg = {shreg[14:0], dac_dat_o};
        bitcnt++; since_rise = 0; hi_run = 0;
      end
      if (prev_c && !dac_clk_o) begin
        if (!first_fall) begin
          chk(settle_run >= SETC, "R5 settle time", settle_run, SETC);
          first_fall = 1;
        end
        if (bitcnt > 0) chk(hi_run == PH, "R2 clock high between bits", hi_run, PH);
        else if (have_word) chk(gap_run >= 4*PH, "R4 inter-word gap", gap_run, 4*PH);
        lo_run = 0;
      end
      if (prev_l && !dac_latch_o) begin
        chk(since_rise == PH, "R3 latch delay after last bit", since_rise, PH);
        chk(bitcnt == 16, "R1 bits per word", bitcnt, 16);
        if (exp_q.size() == 0) chk(0, "R8 unexpected word", shreg, 0);
        else begin
          e = exp_q.pop_front();
          if (words_seen < 4) chk(shreg == e, "R6 boot word", shreg, e);
          else                chk(shreg == e, "R1 host word", shreg, e);
        end
        words_seen++; bitcnt = 0; lat_run = 0;
      end
      if (!prev_l && dac_latch_o) begin
        chk(lat_run == 2*PH, "R3 latch low width", lat_run, 2*PH);
        gap_run = 0; have_word = 1;
      end
      if (req_ready_o && words_seen < 4) boot_ready_bad = 1;
      if (req_ready_o && (!dac_clk_o || !dac_latch_o || bitcnt != 0)) busy_ready_bad = 1;
      if (dac_clk_o) hi_run++; else lo_run++;
      if (dac_latch_o) gap_run++; else lat_run++;
      if (!dac_rst_no) rst_lo_run++;
      else settle_run++;
      if (dac_rst_no && !rst_fell) pre_run++;
      prev_c = dac_clk_o; prev_l = dac_latch_o; prev_r = dac_rst_no;
    end
  end

  task automatic send(input logic [6:0] r, input logic [8:0] v, input bit churn);
    logic [6:0] rr = r;
    logic [8:0] vv = v;
    while (1) begin
      @(negedge clk_i);
      if (churn && !req_ready_o) begin
        rr = 7'($urandom); vv = 9'($urandom);
      end else begin
        rr = r; vv = v;
      end
      req_reg_i = rr; req_val_i = vv; req_valid_i = 1'b1;
      if (req_ready_o) break;
    end
    exp_q.push_back(mk_word(rr, vv));
    n_sent++;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    req_reg_i = 7'($urandom); req_val_i = 9'($urandom);
  endtask

  task automatic wait_idle();
    while (!(req_ready_o && exp_q.size() == 0)) @(negedge clk_i);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_tests++; n_fail++;
    $display("FAIL R1 watchdog expired act=%0d exp=%0d", words_seen, n_sent + 4);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    exp_q.push_back(mk_word(7'd0, 9'h108));
    exp_q.push_back(mk_word(7'd1, 9'h108));
    exp_q.push_back(mk_word(7'd2, 9'h000));
    exp_q.push_back(mk_word(7'd3, 9'h099));
    repeat (3) @(negedge clk_i);
    // R9 reset levels
    chk(dac_clk_o == 1'b1 && dac_latch_o == 1'b1, "R9 clock/latch in reset", {dac_clk_o, dac_latch_o}, 2'b11);
    chk(dac_rst_no == 1'b1, "R9 converter reset idle", dac_rst_no, 1);
    chk(req_ready_o == 1'b0, "R9 ready in reset", req_ready_o, 0);
    rst_ni = 1'b1;
    // request waits from the start of boot
    send(7'h7F, 9'h1FF, 1'b0);
    chk(boot_ready_bad == 0, "R7 ready held low during boot", boot_ready_bad, 0);
    send(7'h00, 9'h000, 1'b0);
    // back-to-back with churning data while busy
    send(7'h15, 9'h0AA, 1'b1);
    send(7'h6A, 9'h155, 1'b1);
    // junk valid pulse while busy must be ignored
    repeat (3) @(negedge clk_i);
    chk(req_ready_o == 1'b0, "R8 ready low mid-word", req_ready_o, 0);
    req_valid_i = 1'b1; req_reg_i = 7'h55; req_val_i = 9'h0F0;
    repeat (5) @(negedge clk_i);
    req_valid_i = 1'b0;
    wait_idle();
    repeat (4*PH) @(negedge clk_i);
    chk(words_seen == n_sent + 4, "R8 no extra word from junk request", words_seen, n_sent + 4);
    for (int i = 0; i < 24; i++) begin
      int idle_n = int'($urandom_range(0, 20));
      repeat (idle_n) @(negedge clk_i);
      send(7'($urandom), 9'($urandom), bit'($urandom_range(0, 1)));
    end
    wait_idle();
    repeat (8*PH) @(negedge clk_i);
    chk(exp_q.size() == 0, "R1 all words delivered", exp_q.size(), 0);
    chk(words_seen == n_sent + 4, "R1 word count", words_seen, n_sent + 4);
    chk(busy_ready_bad == 0, "R8 ready only when idle", busy_ready_bad, 0);
    chk(boot_ready_bad == 0, "R7 no ready before boot end", boot_ready_bad, 0);
    summary();
    $finish;
  end
endmodule